// File: doc/BRIEF.md
# UART Transmitter with RS485 Driver Enable

This block turns bytes offered on a valid/ready input into asynchronous serial characters on a single transmit line. Software-facing logic chooses, per character, a data length of seven or eight bits, one or two stop bits, and one of five parity treatments. The block has no baud generator of its own. Every bit boundary comes from a one-cycle `baud_tick` pulse that an external divider supplies.

Alongside the data line the block drives `tx_en`, the direction control for an RS485 line driver. It is high from the leading edge of the start bit until the tick that closes the last stop bit. It also covers a line break and the idle bit that follows one. No external stretching is needed at any bit rate.

A held `brk_req` forces the line low. If a character is in flight, that character finishes first and the break follows without a gap.

Top module: `serial_tx_de`

## Requirements
- R1: After reset and whenever nothing is being sent, `txd` is 1, `tx_en` is 0 and `in_ready` is 1 (provided `brk_req` is 0).
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the character completes. It is also 0 while `brk_req` is 1 or a break is on the line, and `in_valid` has no effect while `in_ready` is 0.
- R3: The start bit (0) begins on the first `baud_tick` after acceptance. Each later `baud_tick` advances exactly one bit, and data bits follow the start bit least significant first.
- R4: With `cfg_seven`=1 only `in_data[6:0]` is sent and `in_data[7]` has no effect. With `cfg_seven`=0 all eight bits are sent.
- R5: `cfg_parity` selects the bit placed after the last data bit. 0 means no parity bit. 1 (odd) and 2 (even) set the bit so that the data ones plus the parity bit total an odd or even count. 3 sends 1, 4 sends 0, and codes 5 to 7 send no parity bit.
- R6: Stop bits are 1. `cfg_two_stop`=1 sends two of them, and 0 sends one.
- R7: `tx_en` is 1 for every bit of a character, start through final stop bit. It falls, together with `txd` returning to idle, on the `baud_tick` that ends the final stop bit.
- R8: Configuration and data are captured at acceptance. Changing them while the character is in progress does not alter it.
- R9: With `brk_req` at 1 in idle, the next `baud_tick` drives `txd` to 0 with `tx_en` at 1. The line stays low until the first `baud_tick` after `brk_req` drops. One idle bit with `tx_en` still 1 follows, and then the line is idle.
- R10: A break requested during a character waits for that character to finish. On the tick ending its final stop bit, `txd` goes straight to 0 while `tx_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| in_valid | input | 1 | Character offered |
| in_data | input | DATA_W | Character data, bit 0 sent first |
| in_ready | output | 1 | Block can accept a character |
| cfg_seven | input | 1 | 1: seven data bits, 0: eight |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_parity | input | 3 | Parity code (see R5) |
| brk_req | input | 1 | Hold line low (break) while 1 |
| txd | output | 1 | Serial data line, idles at 1 |
| tx_en | output | 1 | RS485 driver enable |

## Verification
Acceptance takes effect on the clock edge that sees `in_valid` with `in_ready`. The line does not move until the clock edge that samples the next `baud_tick`. After that edge, `txd` and `tx_en` reflect the new bit with no further register between.

The bench drives each tick for exactly one cycle, starting at a falling edge, and waits two more cycles before sampling at a later falling edge. Every comparison therefore lands in the bit period that the preceding tick opened. `in_ready` is combinational from state and `brk_req`, so it is compared at the falling edge after any input change.

Expected frames, parity bits and the break sequence are rebuilt in the bench from the requirement text.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_ODD   = 3'd1,
      PAR_EVEN  = 3'd2,
      PAR_MARK  = 3'd3,
      PAR_SPACE = 3'd4
   } parity_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_DATA,
      ST_BRK,
      ST_BRK_END
   } tx_state_t;

endpackage

// File: rtl/serial_tx_parity.sv
module serial_tx_parity
   import serial_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              short_len,
   input  parity_t           mode,
   output logic              pbit,
   output logic              pen
);

   logic [DATA_W-1:0] counted;

   // the top data bit only counts toward parity when the long length is used
   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      if (g == DATA_W - 1) begin : g_top
         assign counted[g] = data[g] & ~short_len;
      end else begin : g_low
         assign counted[g] = data[g];
      end
   end

   always_comb begin
      pbit = 1'b1;
      pen  = 1'b1;
      unique case (mode)
         PAR_ODD:   pbit = ~(^counted);
         PAR_EVEN:  pbit = ^counted;
         PAR_MARK:  pbit = 1'b1;
         PAR_SPACE: pbit = 1'b0;
         default:   pen  = 1'b0;
      endcase
   end

endmodule

// File: rtl/serial_tx_frame.sv
module serial_tx_frame #(
   parameter int DATA_W  = 8,
   parameter int FRAME_W = DATA_W + 4,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] data,
   input  logic              short_len,
   input  logic              two_stop,
   input  logic              pen,
   input  logic              pbit,
   output logic              line_bit,
   output logic              last
);

   localparam int LEN_W   = $clog2(DATA_W + 1);
   localparam int MIN_LEN = DATA_W + 1;

   logic [FRAME_W-1:0] sreg, frame_nxt;
   logic [CNT_W-1:0]   remaining, bits_nxt;
   logic [LEN_W-1:0]   dlen;

   assign dlen = short_len ? LEN_W'(DATA_W - 1) : LEN_W'(DATA_W);

   always_comb begin
      frame_nxt    = '1;
      frame_nxt[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(dlen)) frame_nxt[i + 1] = data[i];
      end
      for (int p = 1; p < FRAME_W; p++) begin
         if (pen && p == int'(dlen) + 1) frame_nxt[p] = pbit;
      end
      bits_nxt = CNT_W'(2) + CNT_W'(dlen) + CNT_W'(pen) + CNT_W'(two_stop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg      <= '1;
         remaining <= '0;
      end else if (load) begin
         sreg      <= frame_nxt;
         remaining <= bits_nxt;
      end else if (shift) begin
         sreg      <= {1'b1, sreg[FRAME_W-1:1]};
         remaining <= remaining - CNT_W'(1);
      end
   end

   assign line_bit = sreg[0];
   assign last     = (remaining == CNT_W'(1));

   assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (remaining >= CNT_W'(MIN_LEN) && remaining <= CNT_W'(FRAME_W)));

   assert_start_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !sreg[0]);

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
   import serial_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic baud_tick,
   input  logic in_valid,
   input  logic brk_req,
   input  logic last,
   input  logic line_bit,
   output logic in_ready,
   output logic load,
   output logic shift,
   output logic txd,
   output logic tx_en
);

   tx_state_t state, state_nxt;

   assign in_ready = (state == ST_IDLE) && !brk_req;
   assign load     = in_valid && in_ready;
   assign shift    = (state == ST_DATA) && baud_tick && !last;

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:    if (brk_req && baud_tick) state_nxt = ST_BRK;
                     else if (load)            state_nxt = ST_WAIT;
         ST_WAIT:    if (baud_tick)            state_nxt = ST_DATA;
         ST_DATA:    if (baud_tick && last)    state_nxt = brk_req ? ST_BRK : ST_IDLE;
         ST_BRK:     if (baud_tick && !brk_req) state_nxt = ST_BRK_END;
         ST_BRK_END: if (baud_tick)            state_nxt = ST_IDLE;
         default:                              state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nxt;
   end

   assign tx_en = (state == ST_DATA) || (state == ST_BRK) || (state == ST_BRK_END);
   assign txd   = (state == ST_DATA) ? line_bit : (state != ST_BRK);

   assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> txd);

   assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> !in_ready);

   assert_enable_starts_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> !txd);

   assert_bits_move_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !baud_tick) |=> ($stable(txd) && tx_en));

   assert_enable_falls_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> $past(baud_tick));

   assert_break_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BRK && brk_req) |=> (!txd && tx_en));

endmodule

// File: rtl/serial_tx_de.sv
module serial_tx_de
   import serial_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              cfg_seven,
   input  logic              cfg_two_stop,
   input  logic [2:0]        cfg_parity,
   input  logic              brk_req,
   output logic              txd,
   output logic              tx_en
);

   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("serial_tx_de: DATA_W must lie in 5..16");
   end

   logic pbit, pen, line_bit, last, load, shift;

   serial_tx_parity #(.DATA_W(DATA_W)) u_parity (
      .data      (in_data),
      .short_len (cfg_seven),
      .mode      (parity_t'(cfg_parity)),
      .pbit      (pbit),
      .pen       (pen)
   );

   serial_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .shift     (shift),
      .data      (in_data),
      .short_len (cfg_seven),
      .two_stop  (cfg_two_stop),
      .pen       (pen),
      .pbit      (pbit),
      .line_bit  (line_bit),
      .last      (last)
   );

   serial_tx_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .in_valid  (in_valid),
      .brk_req   (brk_req),
      .last      (last),
      .line_bit  (line_bit),
      .in_ready  (in_ready),
      .load      (load),
      .shift     (shift),
      .txd       (txd),
      .tx_en     (tx_en)
   );

endmodule

// File: tb/test_serial_tx_de.sv
`timescale 1ns/1ps
module test_serial_tx_de;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic       cfg_seven = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic [2:0] cfg_parity = 3'd0;
   logic       brk_req = 1'b0;
   logic       txd, tx_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   serial_tx_de #(.DATA_W(8)) i_serial_tx_de (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .cfg_seven(cfg_seven),
      .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity), .brk_req(brk_req),
      .txd(txd), .tx_en(tx_en)
   );

   task automatic chk(input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input logic sev, input logic two,
                            input logic [2:0] par, input bit brk_mid, input string name);
      logic exp_bits[12];
      int   n, len, ones;
      string tag;
      len = sev ? 7 : 8;
      ones = 0;
      n = 0;
      exp_bits[n++] = 1'b0;
      for (int i = 0; i < len; i++) begin
         exp_bits[n++] = d[i];
         if (d[i]) ones++;
      end
      case (par)
         3'd1: exp_bits[n++] = (ones % 2 == 0);
         3'd2: exp_bits[n++] = (ones % 2 == 1);
         3'd3: exp_bits[n++] = 1'b1;
         3'd4: exp_bits[n++] = 1'b0;
         default: ;
      endcase
      exp_bits[n++] = 1'b1;
      if (two) exp_bits[n++] = 1'b1;

      @(negedge clk);
      in_valid = 1'b1; in_data = d;
      cfg_seven = sev; cfg_two_stop = two; cfg_parity = par;
      #1 chk(in_ready, 1'b1, {name, " R2 ready before accept"});
      @(negedge clk);
      in_valid = 1'b0;
      in_data = ~d; cfg_seven = ~sev; cfg_two_stop = ~two; cfg_parity = par ^ 3'd3;
      chk(in_ready, 1'b0, {name, " R2 ready low after accept"});
      chk(tx_en, 1'b0, {name, " R3 no enable before first tick"});
      chk(txd, 1'b1, {name, " R3 line idle before first tick"});
      for (int k = 0; k < n; k++) begin
         tick();
         if (k == 0)            tag = "R3 start";
         else if (k <= len)     tag = "R4 data";
         else if (k == n - 1 || (two && k == n - 2)) tag = "R6 stop";
         else                   tag = "R5 parity";
         chk(txd, exp_bits[k], $sformatf("%s %s/R8 bit %0d", name, tag, k));
         chk(tx_en, 1'b1, $sformatf("%s R7 enable bit %0d", name, k));
         chk(in_ready, 1'b0, $sformatf("%s R2 busy bit %0d", name, k));
         if (brk_mid && k == 2) brk_req = 1'b1;
      end
      tick();
      if (brk_mid) begin
         chk(txd, 1'b0, {name, " R10 break follows stop bit"});
         chk(tx_en, 1'b1, {name, " R10 enable kept into break"});
      end else begin
         chk(txd, 1'b1, {name, " R7 line idle after stop"});
         chk(tx_en, 1'b0, {name, " R7 enable falls on final tick"});
         chk(in_ready, 1'b1, {name, " R2 ready after character"});
      end
   endtask

   task automatic t_reset();
      chk(txd, 1'b1, "R1 reset txd");
      chk(tx_en, 1'b0, "R1 reset tx_en");
      chk(in_ready, 1'b1, "R1 reset in_ready");
      tick();
      chk(txd, 1'b1, "R1 idle tick leaves line high");
      chk(tx_en, 1'b0, "R1 idle tick leaves enable low");
   endtask

   task automatic t_break_idle();
      @(negedge clk) brk_req = 1'b1; in_valid = 1'b1; in_data = 8'h5A;
      #1 chk(in_ready, 1'b0, "R2 ready low on break request");
      tick();
      chk(txd, 1'b0, "R9 break drives line low");
      chk(tx_en, 1'b1, "R9 enable during break");
      tick(); tick();
      chk(txd, 1'b0, "R9 break held");
      chk(in_ready, 1'b0, "R2 ready low during break");
      @(negedge clk) in_valid = 1'b0;
      brk_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(txd, 1'b0, "R9 low until next tick after release");
      tick();
      chk(txd, 1'b1, "R9 idle bit after break");
      chk(tx_en, 1'b1, "R9 enable covers idle bit");
      tick();
      chk(tx_en, 1'b0, "R9 enable drops after idle bit");
      chk(in_ready, 1'b1, "R9 ready after break");
      tick();
      chk(txd, 1'b1, "R2 held request during break not sent");
      chk(tx_en, 1'b0, "R2 no character started by ignored valid");
   endtask

   task automatic t_break_mid();
      send_char(8'h96, 1'b0, 1'b0, 3'd2, 1'b1, "brk_mid");
      tick();
      chk(txd, 1'b0, "R10 break held after character");
      @(negedge clk) brk_req = 1'b0;
      tick();
      chk(txd, 1'b1, "R10 idle bit after break");
      chk(tx_en, 1'b1, "R10 enable over idle bit");
      tick();
      chk(tx_en, 1'b0, "R10 enable released");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      send_char(8'hA5, 1'b0, 1'b0, 3'd0, 1'b0, "8N1");
      send_char(8'hD3, 1'b1, 1'b1, 3'd2, 1'b0, "7E2");
      send_char(8'h00, 1'b0, 1'b0, 3'd1, 1'b0, "8O1");
      send_char(8'h3C, 1'b0, 1'b0, 3'd3, 1'b0, "8M1");
      send_char(8'hFF, 1'b1, 1'b1, 3'd4, 1'b0, "7S2");
      send_char(8'h81, 1'b0, 1'b1, 3'd6, 1'b0, "8X2");
      send_char(8'h6B, 1'b1, 1'b0, 3'd1, 1'b0, "7O1");
      t_break_idle();
      t_break_mid();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule